// File: doc/BRIEF.md
# Strobe-Qualified Sample FIFO Bus Slave

This block is the FPGA-side endpoint of a host processor's asynchronous external memory bus. The host has an active-low chip-enable, separate active-low read and write strobes, a 14-bit bidirectional data bus, and three address lines. On the board these three lines are routed to the block as a write-select, a read-select and a go-select. The block brings every bus signal into its own clock with a flop chain. Each access is decoded from one select line gated by chip-enable. It then pushes host writes into a sample FIFO, pops the FIFO onto the data bus on host reads, and issues a one-cycle start pulse to an A/D sequencer.

Gating by chip-enable is what keeps the block in its own address window. Without it, any access in another chip-select space that happened to drive one of the select lines would also reach the FIFO. The host strobes cannot be stalled, so there is no back-pressure. A write that finds the FIFO full is dropped and recorded. A read that finds it empty is refused and recorded. A push or pop happens once per strobe, on the cycle in which the synchronised strobe is first seen active.

Top module: `strobe_fifo_slave`

## Requirements
- R1: When chip-enable is low and the write-select line is high, each assertion of the write strobe pushes the value on the data bus into the FIFO exactly once.
- R2: A write or read strobe while chip-enable is high, or while the matching select line is low, leaves the FIFO contents, flags and start output unchanged.
- R3: When chip-enable is low and the read-select line is high, each assertion of the read strobe pops the oldest entry and presents it on the data bus. Entries leave in the order they were written.
- R4: When chip-enable is low and the go-select line is high, each assertion of either strobe gives exactly one clock cycle of `start_pulse`. A strobe with chip-enable high gives none.
- R5: `fifo_empty` is 1 when no entries are held. `fifo_full` is 1 when DEPTH (default 256) entries are held. The two are never 1 together.
- R6: A qualified write while `fifo_full` is 1 stores nothing and sets `overflow`. `overflow` stays 1 until reset, and the entries already held read back intact.
- R7: A qualified read while `fifo_empty` is 1 removes nothing and sets `underflow`. `underflow` stays 1 until reset.
- R8: `bus_drive` is 1, and the block drives the data bus, only while chip-enable, the read strobe and the read-select line are all active. At all other times the bus is left undriven.
- R9: An active-high synchronous reset empties the FIFO and clears `overflow`, `underflow` and `start_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Host chip-enable, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| sel_wr | input | 1 | Address line that selects FIFO write |
| sel_rd | input | 1 | Address line that selects FIFO read |
| sel_go | input | 1 | Address line that selects the start command |
| bus_data | inout | 14 | Bidirectional host data bus |
| bus_drive | output | 1 | High while the block drives `bus_data` |
| start_pulse | output | 1 | One-cycle start request to the A/D sequencer |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| fifo_empty | output | 1 | FIFO holds no entries |
| overflow | output | 1 | Sticky: a write was refused while full |
| underflow | output | 1 | Sticky: a read was refused while empty |

## Verification
The bound checker evaluates these properties on every cycle:
- the full and empty flags exclude each other;
- the start output never lasts more than one cycle;
- both error flags are sticky;
- a refused write leaves the FIFO full;
- no push or pop is decoded while chip-enable is inactive;
- reset clears the outputs.

Other behaviour needs the bench's scenarios, because it depends on values carried across many accesses. This covers first-in first-out ordering over a full sweep of all DEPTH entries, and whether held data survives an overflow attempt. It also covers the number of start pulses per access and the exact data driven onto the bus during a read.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int BUS_W = 14;

  typedef struct packed {
    logic go;
    logic rsel;
    logic wsel;
    logic wr_n;
    logic rd_n;
    logic cs_n;
  } bus_ctl_t;

  localparam int CTL_W = $bits(bus_ctl_t);
  // Idle bus: all active-low controls high, selects low.
  localparam logic [CTL_W-1:0] CTL_IDLE = 6'b000111;
endpackage

// File: rtl/sfb_sync.sv
module sfb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sfb_decode.sv
module sfb_decode
  import sfb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  bus_ctl_t ctl,
  output logic     cs_act,
  output logic     push_req,
  output logic     pop_req,
  output logic     start_q,
  output logic     drive_q
);
  logic wr_act, rd_act;
  logic wr_prev, rd_prev;
  logic wr_edge, rd_edge;
  logic go_req;

  assign cs_act  = ~ctl.cs_n;
  assign wr_act  = ~ctl.wr_n;
  assign rd_act  = ~ctl.rd_n;
  assign wr_edge = wr_act & ~wr_prev;
  assign rd_edge = rd_act & ~rd_prev;

  // Every command is gated by chip-enable.
  assign push_req = cs_act & ctl.wsel & wr_edge;
  assign pop_req  = cs_act & ctl.rsel & rd_edge;
  assign go_req   = cs_act & ctl.go & (wr_edge | rd_edge);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
      start_q <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      wr_prev <= wr_act;
      rd_prev <= rd_act;
      start_q <= go_req;
      drive_q <= cs_act & rd_act & ctl.rsel;
    end
  end
endmodule

// File: rtl/sfb_fifo.sv
module sfb_fifo #(
  parameter int W = 14,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_req,
  input  logic [W-1:0] push_data,
  input  logic         pop_req,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty,
  output logic         ovf,
  output logic         udf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_req & ~full;
  assign pop_ok  = pop_req & ~empty;

  if (POW2) begin : g_wrap_free
    assign wptr_nx = wptr + 1'b1;
    assign rptr_nx = rptr + 1'b1;
  end else begin : g_wrap_cmp
    assign wptr_nx = (wptr == LAST) ? '0 : wptr + 1'b1;
    assign rptr_nx = (rptr == LAST) ? '0 : rptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      ovf      <= 1'b0;
      udf      <= 1'b0;
      pop_data <= '0;
    end else begin
      if (push_ok) wptr <= wptr_nx;
      if (pop_ok) begin
        rptr     <= rptr_nx;
        pop_data <= mem[rptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_req && full)  ovf <= 1'b1;
      if (pop_req  && empty) udf <= 1'b1;
    end
  end
endmodule

// File: rtl/strobe_fifo_slave.sv
module strobe_fifo_slave
  import sfb_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_cs_n,
  input  logic             bus_rd_n,
  input  logic             bus_wr_n,
  input  logic             sel_wr,
  input  logic             sel_rd,
  input  logic             sel_go,
  inout  wire [BUS_W-1:0]  bus_data,
  output logic             bus_drive,
  output logic             start_pulse,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic             overflow,
  output logic             underflow
);
  bus_ctl_t         ctl_raw, ctl_s;
  logic [CTL_W-1:0] ctl_s_vec;
  logic [BUS_W-1:0] data_s, rd_word;
  logic             cs_act, push_req, pop_req;

  assign ctl_raw = '{go: sel_go, rsel: sel_rd, wsel: sel_wr,
                     wr_n: bus_wr_n, rd_n: bus_rd_n, cs_n: bus_cs_n};

  sfb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s_vec)
  );
  assign ctl_s = bus_ctl_t'(ctl_s_vec);

  sfb_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst(rst), .d(bus_data), .q(data_s)
  );

  sfb_decode u_dec (
    .clk(clk), .rst(rst), .ctl(ctl_s),
    .cs_act(cs_act), .push_req(push_req), .pop_req(pop_req),
    .start_q(start_pulse), .drive_q(bus_drive)
  );

  sfb_fifo #(.W(BUS_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push_req(push_req), .push_data(data_s),
    .pop_req(pop_req), .pop_data(rd_word),
    .full(fifo_full), .empty(fifo_empty),
    .ovf(overflow), .udf(underflow)
  );

  assign bus_data = bus_drive ? rd_word : 'z;
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker (
  input logic clk,
  input logic rst,
  input logic cs_act,
  input logic push_req,
  input logic pop_req,
  input logic start_pulse,
  input logic fifo_full,
  input logic fifo_empty,
  input logic overflow,
  input logic underflow
);
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  a_r4_single_start: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && push_req && !pop_req) |=> (fifo_full && overflow));

  a_r2_cs_gates: assert property (@(posedge clk) disable iff (rst)
    !cs_act |-> (!push_req && !pop_req));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (fifo_empty && !overflow && !underflow && !start_pulse));
endmodule

bind strobe_fifo_slave sfb_checker u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .push_req(push_req),
  .pop_req(pop_req), .start_pulse(start_pulse), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .overflow(overflow), .underflow(underflow)
);

// File: tb/strobe_fifo_slave_test.sv
module strobe_fifo_slave_test;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic s_wr = 1'b0, s_rd = 1'b0, s_go = 1'b0;
  logic tb_drv = 1'b0;
  logic [13:0] tb_val = '0;
  wire  [13:0] dbus;
  logic drive, start, full, empty, ovf, udf;

  int checks = 0, fails = 0, pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign dbus = tb_drv ? tb_val : 'z;

  strobe_fifo_slave #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
    .sel_wr(s_wr), .sel_rd(s_rd), .sel_go(s_go), .bus_data(dbus),
    .bus_drive(drive), .start_pulse(start), .fifo_full(full),
    .fifo_empty(empty), .overflow(ovf), .underflow(udf)
  );

  always @(negedge clk) if (start) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] pat(input int i);
    return 14'((i * 37 + 5) & 16'h3fff);
  endfunction

  // One host access; returns bus value and drive flag seen mid-strobe.
  task automatic access(input logic cs, input logic ws, input logic rs,
                        input logic go, input logic is_rd, input logic [13:0] wd,
                        output logic [13:0] rv, output logic dv);
    @(negedge clk);
    cs_n = ~cs; s_wr = ws; s_rd = rs; s_go = go;
    tb_drv = ~is_rd; tb_val = wd;
    repeat (3) @(negedge clk);
    if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
    repeat (6) @(negedge clk);
    rv = dbus; dv = drive;
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; s_wr = 0; s_rd = 0; s_go = 0; tb_drv = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [13:0] rv;
    logic dv;
    int p0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R9 / R5: reset state
    chk(empty && !full && !ovf && !udf && !start && !drive, "R9", {empty,full,ovf,udf}, 8);

    // R2: unqualified writes and reads change nothing
    access(0, 1, 0, 0, 0, 14'h1234, rv, dv);
    access(1, 0, 0, 0, 0, 14'h0abc, rv, dv);
    access(0, 0, 1, 0, 1, 14'h0, rv, dv);
    chk(empty && !udf && pulses == 0, "R2", {empty, udf}, 2);

    // R8: no drive during write or during read without read-select
    access(1, 0, 0, 0, 1, 14'h0, rv, dv);
    chk(!dv, "R8", dv, 0);
    chk(empty && !udf, "R2", {empty, udf}, 2);

    // R4: start pulses
    p0 = pulses;
    access(1, 0, 0, 1, 0, 14'h0, rv, dv);
    chk(pulses - p0 == 1, "R4", pulses - p0, 1);
    p0 = pulses;
    access(1, 0, 0, 1, 1, 14'h0, rv, dv);
    chk(pulses - p0 == 1, "R4", pulses - p0, 1);
    p0 = pulses;
    access(0, 0, 0, 1, 0, 14'h0, rv, dv);
    access(0, 0, 0, 1, 1, 14'h0, rv, dv);
    chk(pulses == p0, "R4", pulses - p0, 0);

    // R1 / R3 / R8: single write then read
    access(1, 1, 0, 0, 0, 14'h2d5a, rv, dv);
    chk(!empty && !full, "R1", empty, 0);
    access(1, 0, 1, 0, 1, 14'h0, rv, dv);
    chk(dv, "R8", dv, 1);
    chk(rv == 14'h2d5a, "R3", rv, 14'h2d5a);
    chk(empty && !udf, "R3", {empty, udf}, 2);

    // R1 / R5: full sweep, write all entries
    for (int i = 0; i < DEPTH; i++) begin
      access(1, 1, 0, 0, 0, pat(i), rv, dv);
      if (i == DEPTH - 2) chk(!full, "R5", full, 0);
    end
    chk(full && !empty, "R5", {full, empty}, 2);

    // R6: write while full
    access(1, 1, 0, 0, 0, 14'h3fff, rv, dv);
    chk(full && ovf, "R6", {full, ovf}, 3);

    // R3 / R6: ordered read-back, data intact
    for (int i = 0; i < DEPTH; i++) begin
      access(1, 0, 1, 0, 1, 14'h0, rv, dv);
      chk(rv == pat(i), "R3", rv, pat(i));
    end
    chk(empty && ovf, "R6", {empty, ovf}, 3);

    // R7: read while empty
    access(1, 0, 1, 0, 1, 14'h0, rv, dv);
    chk(empty && udf && ovf, "R7", {empty, udf, ovf}, 7);

    // R9: reset clears sticky flags
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(empty && !ovf && !udf && !start, "R9", {ovf, udf}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule